// File: doc/BRIEF.md
# Dual-Framing BPSK Frame Decoder

This block turns a stream of signed I/Q subcarrier samples, delivered at two samples per elementary time unit (etu), into the bytes of a proximity-card response. It first locks onto the unmodulated subcarrier tone and learns its phase. It then slices every etu into a bit against that reference and strips the character framing. Each recovered byte is presented with a one-cycle strobe. A second strobe closes the frame, and a third reports any abort back to idle.

Two response framings are accepted by one state machine. In the long-SOF framing, the tone is followed by a low period of 10 to 12 etu and then a short high period before the first character. In the short framing, the first start bit follows the tone directly. A character made only of zeros has two meanings. Before any byte has been stored, it is taken as the middle of a long SOF. After at least one byte, it is the end of the frame. A tag-active flag tells a surrounding sniffer that the card is past its start-of-frame and is sending characters.

Top module: `bpsk_dual_frame_rx`

## Requirements
- R1: Out of reset all strobes and `tag_active` are low. From idle, the first valid sample with |I|+|Q| greater than `THRESH` starts reference training, and that sample becomes the initial reference.
- R2: During training, a sample whose amplitude is not above `THRESH`, or a phase reversal seen before `TRAIN_LEN` agreeing samples, returns the block to idle with a one-cycle `frame_err`.
- R3: A training sample agrees with the reference when its sign matches the reference sum on the larger-magnitude axis (I when |ΣI| > |ΣQ|, otherwise Q). Only the first `TRAIN_LEN` samples are added to the sums, so decoding works for a tone of any direction.
- R4: A phase reversal after at least `TRAIN_LEN` agreeing samples is the first half of the first bit. Each bit is 1 when I·ΣI + Q·ΣQ > 0 on the second sample of its etu, and 0 otherwise. A character may therefore follow the tone with no SOF low period.
- R5: A character is a 0 start bit, 8 data bits least significant first, and a 1 stop bit. A good character pulses `byte_valid` with the data on `byte_data`. A character that is neither good nor all zeros gives `frame_err` and returns to idle.
- R6: Any number of whole etus of 1 between a stop bit and the next start bit is ignored.
- R7: An all-zero character after at least one byte pulses `frame_done` and returns to idle.
- R8: An all-zero character before any byte presets a low counter to 20 samples. The counter then advances on every low sample. A 1 sample ends the SOF, and it is accepted when the count is at least 18. A low count above 24 gives `frame_err`. So a SOF low of 20 to 24 samples is accepted and one of 25 is rejected.
- R9: `tag_active` is high only while the block waits for a start bit or receives a character. It is low during idle, during training and while waiting for the end of the SOF low period.
- R10: A good character arriving when `MAX_BYTES` bytes are already stored gives `frame_err` without a `byte_valid`, and the block returns to idle.
- R11: Cycles with `smp_valid` low change no state and no output.
- R12: `byte_valid`, `frame_done` and `frame_err` last one cycle each, and no two of them are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Qualifies the sample pair on this cycle |
| smp_i | input | SMP_W | In-phase sample, signed |
| smp_q | input | SMP_W | Quadrature sample, signed |
| byte_valid | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | CHAR_BITS-2 | Byte value, valid with `byte_valid` |
| frame_done | output | 1 | One-cycle pulse on end of frame |
| frame_err | output | 1 | One-cycle pulse on an abort to idle |
| tag_active | output | 1 | High while characters are expected or being received |

## Verification
The decoder is driven with long-SOF frames and short-framing frames, using tones whose reference points along I, along Q, and at mixed angles. This separates correct dominant-axis selection and dot-product slicing from a decoder that only works for one tone direction. SOF low periods of exactly 20 and 24 samples must decode, while 25 samples must abort, which pins down the window limits. Frames with stuffing etus and frames with idle gaps between samples must produce the same bytes as clean ones. Short training tones, a bad stop bit and a fifth byte with `MAX_BYTES` set to 4 must each give exactly one `frame_err` and no spurious byte.

// File: rtl/bpskdec_pkg.sv
// Package: shared types for the dual-framing BPSK frame decoder.
// Assumes the state ordering below; tag_active relies on it (states after
// ST_SOF_WAIT are the ones where the card is sending characters).
package bpskdec_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_TRAIN      = 3'd1,
        ST_SOF_WAIT   = 3'd2,
        ST_WAIT_START = 3'd3,
        ST_RX_CHAR    = 3'd4
    } rx_state_t;
endpackage

// File: rtl/bpskdec_slicer.sv
// Module: combinational sample classifier.
// Computes carrier presence (|I|+|Q| above THRESH), agreement of the sample
// with the reference on its dominant axis, and the soft bit (sign of the dot
// product with the reference sums). Assumes signed two's-complement inputs.
module bpskdec_slicer #(
    parameter int SMP_W  = 8,
    parameter int SUM_W  = 13,
    parameter int THRESH = 20
) (
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic signed [SMP_W-1:0] smp_q,
    input  logic signed [SUM_W-1:0] sum_i,
    input  logic signed [SUM_W-1:0] sum_q,
    output logic                    carrier,
    output logic                    same_phase,
    output logic                    soft_bit
);
    localparam int AMP_W = SMP_W + 2;
    localparam int DOT_W = SMP_W + SUM_W + 1;

    logic signed [SMP_W:0]   ext_i, ext_q;
    logic        [SMP_W:0]   abs_i, abs_q;
    logic        [AMP_W-1:0] amp;
    logic signed [SUM_W:0]   ext_si, ext_sq;
    logic        [SUM_W:0]   abs_si, abs_sq;
    logic signed [DOT_W-1:0] dot;
    logic                    i_dom;

    // Amplitude estimate and carrier detect
    always_comb begin
        ext_i   = (SMP_W+1)'(smp_i);
        ext_q   = (SMP_W+1)'(smp_q);
        abs_i   = ext_i[SMP_W] ? -ext_i : ext_i;
        abs_q   = ext_q[SMP_W] ? -ext_q : ext_q;
        amp     = {1'b0, abs_i} + {1'b0, abs_q};
        carrier = amp > AMP_W'(THRESH);
    end

    // Dominant-axis sign agreement used during training
    always_comb begin
        ext_si = (SUM_W+1)'(sum_i);
        ext_sq = (SUM_W+1)'(sum_q);
        abs_si = ext_si[SUM_W] ? -ext_si : ext_si;
        abs_sq = ext_sq[SUM_W] ? -ext_sq : ext_sq;
        i_dom  = abs_si > abs_sq;
        if (i_dom)
            same_phase = (!smp_i[SMP_W-1] && smp_i != '0 && !sum_i[SUM_W-1] && sum_i != '0) ||
                         (smp_i[SMP_W-1] && sum_i[SUM_W-1]);
        else
            same_phase = (!smp_q[SMP_W-1] && smp_q != '0 && !sum_q[SUM_W-1] && sum_q != '0) ||
                         (smp_q[SMP_W-1] && sum_q[SUM_W-1]);
    end

    // Soft decision: positive correlation with the reference codes a 1
    always_comb begin
        dot      = DOT_W'(smp_i) * DOT_W'(sum_i) + DOT_W'(smp_q) * DOT_W'(sum_q);
        soft_bit = !dot[DOT_W-1] && (dot != '0);
    end
endmodule

// File: rtl/bpskdec_refacc.sv
// Module: reference phase accumulator.
// Loads the first carrier sample, then adds agreeing samples until TRAIN_LEN
// samples are summed; later agreeing samples leave the sums untouched.
// Assumes load and accum are never high together.
module bpskdec_refacc #(
    parameter int SMP_W     = 8,
    parameter int SUM_W     = 13,
    parameter int TRAIN_LEN = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    accum,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic signed [SMP_W-1:0] smp_q,
    output logic signed [SUM_W-1:0] sum_i,
    output logic signed [SUM_W-1:0] sum_q,
    output logic                    trained
);
    localparam int CNT_W = $clog2(TRAIN_LEN + 1);

    logic [CNT_W-1:0] cnt_q;

    // Reference sums and training sample count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_i <= '0;
            sum_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sum_i <= SUM_W'(smp_i);
            sum_q <= SUM_W'(smp_q);
            cnt_q <= CNT_W'(1);
        end else if (accum && cnt_q < CNT_W'(TRAIN_LEN)) begin
            sum_i <= sum_i + SUM_W'(smp_i);
            sum_q <= sum_q + SUM_W'(smp_q);
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign trained = cnt_q >= CNT_W'(TRAIN_LEN);

    // R3: once training is complete the reference no longer moves
    a_r3_ref_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (trained && !load) |=> ($stable(sum_i) && $stable(sum_q)));
endmodule

// File: rtl/bpskdec_charreg.sv
// Module: character shift register and bit counter.
// Bits enter at the top so the first bit received ends up at bit 0.
// Presents the complete character combinationally on the shift that fills it.
module bpskdec_charreg #(
    parameter int CHAR_BITS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 shift,
    input  logic                 bit_in,
    output logic [CHAR_BITS-1:0] next_char,
    output logic                 last_bit
);
    localparam int BC_W = $clog2(CHAR_BITS);

    logic [CHAR_BITS-2:0] sh_q;
    logic [BC_W-1:0]      bcnt_q;

    assign next_char = {bit_in, sh_q};
    assign last_bit  = bcnt_q == BC_W'(CHAR_BITS - 1);

    // Shift in one decided bit and count bits within the character
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bcnt_q <= '0;
        end else if (clear) begin
            bcnt_q <= '0;
        end else if (shift) begin
            sh_q   <= next_char[CHAR_BITS-1:1];
            bcnt_q <= last_bit ? '0 : bcnt_q + BC_W'(1);
        end
    end

    // R5: bit counter never passes the character length
    a_r5_bitcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt_q < BC_W'(CHAR_BITS));
endmodule

// File: rtl/bpsk_dual_frame_rx.sv
// Module: dual-framing BPSK frame decoder (top).
// Trains on the subcarrier tone, slices one bit per two samples, deframes
// start/data/stop characters and handles both long-SOF and short framing in
// one state machine. Assumes two samples per etu and a synchronous reset.
module bpsk_dual_frame_rx
    import bpskdec_pkg::*;
#(
    parameter int SMP_W      = 8,
    parameter int THRESH     = 20,
    parameter int TRAIN_LEN  = 10,
    parameter int SOF_PRESET = 20,
    parameter int SOF_MIN    = 18,
    parameter int SOF_MAX    = 24,
    parameter int MAX_BYTES  = 256,
    parameter int CHAR_BITS  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic signed [SMP_W-1:0] smp_q,
    output logic                    byte_valid,
    output logic [CHAR_BITS-3:0]    byte_data,
    output logic                    frame_done,
    output logic                    frame_err,
    output logic                    tag_active
);
    localparam int SUM_W  = SMP_W + $clog2(TRAIN_LEN) + 1;
    localparam int BCNT_W = $clog2(MAX_BYTES + 1);
    localparam int LCNT_W = $clog2(SOF_MAX + 2);

    rx_state_t            state_q;
    logic                 half_q;
    logic [LCNT_W-1:0]    low_cnt_q;
    logic [LCNT_W-1:0]    low_cnt_nx;
    logic [BCNT_W-1:0]    byte_cnt_q;

    logic signed [SUM_W-1:0] sum_i, sum_q;
    logic                    carrier, same_phase, soft_bit, trained;
    logic                    ref_load, ref_acc, chr_clear, chr_shift;
    logic [CHAR_BITS-1:0]    nchar;
    logic                    chr_last;
    logic                    char_good, char_zero;

    bpskdec_slicer #(.SMP_W(SMP_W), .SUM_W(SUM_W), .THRESH(THRESH)) u_slicer (
        .smp_i(smp_i), .smp_q(smp_q), .sum_i(sum_i), .sum_q(sum_q),
        .carrier(carrier), .same_phase(same_phase), .soft_bit(soft_bit)
    );

    bpskdec_refacc #(.SMP_W(SMP_W), .SUM_W(SUM_W), .TRAIN_LEN(TRAIN_LEN)) u_refacc (
        .clk(clk), .rst_n(rst_n), .load(ref_load), .accum(ref_acc),
        .smp_i(smp_i), .smp_q(smp_q), .sum_i(sum_i), .sum_q(sum_q), .trained(trained)
    );

    bpskdec_charreg #(.CHAR_BITS(CHAR_BITS)) u_charreg (
        .clk(clk), .rst_n(rst_n), .clear(chr_clear), .shift(chr_shift),
        .bit_in(soft_bit), .next_char(nchar), .last_bit(chr_last)
    );

    // Control strobes for the reference accumulator and character register
    always_comb begin
        ref_load  = smp_valid && state_q == ST_IDLE && carrier;
        ref_acc   = smp_valid && state_q == ST_TRAIN && carrier && same_phase;
        chr_shift = smp_valid && state_q == ST_RX_CHAR && half_q;
        chr_clear = smp_valid &&
                    ((state_q == ST_TRAIN && carrier && !same_phase && trained) ||
                     (state_q == ST_WAIT_START && !soft_bit) ||
                     (state_q == ST_SOF_WAIT && soft_bit));
        char_good  = !nchar[0] && nchar[CHAR_BITS-1];
        char_zero  = nchar == '0;
        low_cnt_nx = low_cnt_q + LCNT_W'(1);
    end

    // Frame state machine with registered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            half_q     <= 1'b0;
            low_cnt_q  <= '0;
            byte_cnt_q <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
            if (smp_valid) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (carrier) begin
                            state_q    <= ST_TRAIN;
                            byte_cnt_q <= '0;
                        end
                    end
                    ST_TRAIN: begin
                        if (!carrier) begin
                            state_q   <= ST_IDLE;
                            frame_err <= 1'b1;
                        end else if (!same_phase) begin
                            if (trained) begin
                                state_q <= ST_RX_CHAR;
                                half_q  <= 1'b1;
                            end else begin
                                state_q   <= ST_IDLE;
                                frame_err <= 1'b1;
                            end
                        end
                    end
                    ST_RX_CHAR: begin
                        half_q <= !half_q;
                        if (half_q && chr_last) begin
                            if (char_good) begin
                                if (byte_cnt_q == BCNT_W'(MAX_BYTES)) begin
                                    state_q   <= ST_IDLE;
                                    frame_err <= 1'b1;
                                end else begin
                                    byte_valid <= 1'b1;
                                    byte_data  <= nchar[CHAR_BITS-2:1];
                                    byte_cnt_q <= byte_cnt_q + BCNT_W'(1);
                                    state_q    <= ST_WAIT_START;
                                end
                            end else if (char_zero) begin
                                if (byte_cnt_q != '0) begin
                                    frame_done <= 1'b1;
                                    state_q    <= ST_IDLE;
                                end else begin
                                    low_cnt_q <= LCNT_W'(SOF_PRESET);
                                    state_q   <= ST_SOF_WAIT;
                                end
                            end else begin
                                state_q   <= ST_IDLE;
                                frame_err <= 1'b1;
                            end
                        end
                    end
                    ST_WAIT_START: begin
                        if (!soft_bit) begin
                            state_q <= ST_RX_CHAR;
                            half_q  <= 1'b1;
                        end
                    end
                    ST_SOF_WAIT: begin
                        if (soft_bit) begin
                            if (low_cnt_nx < LCNT_W'(SOF_MIN)) begin
                                state_q   <= ST_IDLE;
                                frame_err <= 1'b1;
                            end else begin
                                byte_cnt_q <= '0;
                                state_q    <= ST_WAIT_START;
                            end
                        end else if (low_cnt_nx > LCNT_W'(SOF_MAX)) begin
                            state_q   <= ST_IDLE;
                            frame_err <= 1'b1;
                        end else begin
                            low_cnt_q <= low_cnt_nx;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign tag_active = state_q > ST_SOF_WAIT;

    // R12: result strobes are mutually exclusive
    a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_valid, frame_done, frame_err}));
    // R7: a frame can only end from an active reception
    a_r7_done_from_active: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(tag_active));
    // R9: after a byte the block waits for the next start bit, still active
    a_r9_active_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> tag_active);
    // R10: stored byte count never exceeds the limit
    a_r10_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt_q <= BCNT_W'(MAX_BYTES));
    // R11: a cycle without a sample leaves the state unchanged
    a_r11_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(state_q));
    // R8: low counter stays inside the SOF window while waiting
    a_r8_low_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SOF_WAIT) |->
            (low_cnt_q >= LCNT_W'(SOF_PRESET) && low_cnt_q <= LCNT_W'(SOF_MAX)));
endmodule

// File: tb/bpsk_dual_frame_rx_tb.sv
// Scoreboard bench: driver tasks queue expected events (byte, done, error),
// a negedge monitor pops and compares them as the decoder emits results.
module bpsk_dual_frame_rx_tb;
    localparam int EV_DONE = 256;
    localparam int EV_ERR  = 257;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic signed [7:0] smp_i = '0;
    logic signed [7:0] smp_q = '0;
    logic              byte_valid, frame_done, frame_err, tag_active;
    logic [7:0]        byte_data;

    int    checks = 0;
    int    errors = 0;
    int    ri = 40;
    int    rq = 30;
    bit    gap_mode = 1'b0;
    bit    finished = 1'b0;
    int    exp_q[$];
    string req_q[$];

    always #5 clk = ~clk;

    bpsk_dual_frame_rx #(.MAX_BYTES(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
        .byte_valid(byte_valid), .byte_data(byte_data), .frame_done(frame_done),
        .frame_err(frame_err), .tag_active(tag_active)
    );

    function automatic void chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endfunction

    function automatic void push(int code, string req);
        exp_q.push_back(code);
        req_q.push_back(req);
    endfunction

    function automatic void take(int got);
        int    e;
        string r;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R12", "unexpected event", got, -1);
        end else begin
            e = exp_q.pop_front();
            r = req_q.pop_front();
            chk(got == e, r, "event", got, e);
        end
    endfunction

    // Monitor: compare every emitted strobe against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) take(int'(byte_data));
            if (frame_done) take(EV_DONE);
            if (frame_err)  take(EV_ERR);
        end
    end

    task automatic smp(input int i, input int q);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_i = 8'(i);
        smp_q = 8'(q);
        if (gap_mode) begin
            @(negedge clk);
            smp_valid = 1'b0;
            smp_i = -8'sd128;
            smp_q = 8'sd17;
        end
    endtask

    task automatic pause();
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic quiet(input int n);
        for (int k = 0; k < n; k++) smp(0, 0);
    endtask

    task automatic high(input int n);
        for (int k = 0; k < n; k++) smp(ri, rq);
    endtask

    task automatic low(input int n);
        for (int k = 0; k < n; k++) smp(-ri, -rq);
    endtask

    task automatic etu(input bit b);
        if (b) high(2); else low(2);
    endtask

    task automatic send_char(input logic [7:0] d, input bit stop);
        etu(1'b0);
        for (int k = 0; k < 8; k++) etu(d[k]);
        etu(stop);
    endtask

    task automatic send_byte(input logic [7:0] d, input string req);
        push(int'(d), req);
        send_char(d, 1'b1);
    endtask

    task automatic std_open(input int low_len);
        quiet(4); high(20); low(low_len); high(6);
    endtask

    task automatic alt_open();
        quiet(4); high(16);
    endtask

    task automatic close_frame(input string req);
        push(EV_DONE, req);
        for (int k = 0; k < 10; k++) etu(1'b0);
        quiet(6);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({byte_valid, frame_done, frame_err, tag_active} == 4'b0, "R1", "reset outputs",
            int'({byte_valid, frame_done, frame_err, tag_active}), 0);

        // Long-SOF frame with tag_active probes (R1 R8 R9 R5 R7)
        quiet(4); high(20); pause();
        chk(tag_active == 1'b0, "R9", "tag_active in training", int'(tag_active), 0);
        low(21); pause();
        chk(tag_active == 1'b0, "R9", "tag_active in SOF wait", int'(tag_active), 0);
        low(1); high(1); pause();
        chk(tag_active == 1'b1, "R8", "tag_active after SOF edge", int'(tag_active), 1);
        high(5);
        send_byte(8'h5A, "R5");
        send_byte(8'hC3, "R5");
        close_frame("R7");
        pause();
        chk(tag_active == 1'b0, "R7", "tag_active after frame", int'(tag_active), 0);

        // Short framing, Q-dominant reference (R3 R4)
        ri = -10; rq = -50;
        alt_open();
        send_byte(8'h01, "R4");
        send_byte(8'h80, "R3");
        send_byte(8'hFF, "R4");
        close_frame("R7");

        // Stuffing etus between characters, mixed-angle reference (R6)
        ri = -45; rq = 5;
        alt_open();
        send_byte(8'h96, "R6");
        etu(1'b1); etu(1'b1); etu(1'b1);
        send_byte(8'h0F, "R6");
        etu(1'b1);
        close_frame("R6");

        // Idle gaps between samples (R11)
        ri = 40; rq = 30;
        gap_mode = 1'b1;
        alt_open();
        send_byte(8'hA5, "R11");
        send_byte(8'h3C, "R11");
        close_frame("R11");
        gap_mode = 1'b0;

        // SOF window limits: 20 and 24 low samples accepted (R8)
        std_open(20);
        send_byte(8'h00, "R8");
        close_frame("R8");
        std_open(24);
        send_byte(8'h7E, "R8");
        close_frame("R8");

        // SOF low of 25 samples rejected (R8)
        push(EV_ERR, "R8");
        quiet(4); high(20); low(25); quiet(6);

        // Training aborted by amplitude loss (R2)
        push(EV_ERR, "R2");
        quiet(4); high(5); quiet(6);

        // Training aborted by early phase reversal (R2)
        push(EV_ERR, "R2");
        quiet(4); high(6); low(1); quiet(6);

        // Bad stop bit (R5)
        alt_open();
        push(EV_ERR, "R5");
        send_char(8'h55, 1'b0);
        quiet(6);

        // Byte limit of 4 exceeded (R10)
        alt_open();
        send_byte(8'h11, "R10");
        send_byte(8'h22, "R10");
        send_byte(8'h33, "R10");
        send_byte(8'h44, "R10");
        push(EV_ERR, "R10");
        send_char(8'h55, 1'b1);
        quiet(6);
        pause();
        chk(tag_active == 1'b0, "R10", "idle after overflow", int'(tag_active), 0);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R12", "events still expected", exp_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule